// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a branch is taken. It looks at three fields of the current instruction word: the 4-bit class, the 4-bit condition code and the 4-bit destination field. It tests the condition against an 8-bit flag register that it keeps itself. The condition codes come in pairs. Code 0 means "always". Each odd code tests one flag for one, and the even code that follows tests the same flag for zero. The flags are taken in order from the lowest to the highest, so that codes 15 through 1 together cover all eight flags.

The block also stores the flags. When the ALU raises its update strobe, the low four flags (zero, negative, carry, overflow) are loaded. A separate restore strobe loads all eight flags at once, as needed when returning from a call. For words of the immediate class, two outputs say whether the word is a conditional branch or an immediate ALU operation. The destination field settles this. The program counter update and the relative-offset adder sit outside this block. That adder takes a signed 16-bit offset (-32768 to 32767) relative to the current instruction address.

The instruction fields and the strobes are plain control pins. They carry no handshake and no back-pressure: each field is valid for as long as it is presented.

Top module: `brcond_eval`

## Requirements
- R1: After reset, all eight flags read 0. As a result, condition code 10 (F4 clear) is taken for a branch-class word.
- R2: Condition code 0 is taken for every branch-class word, whatever the flags hold.
- R3: An odd condition code c (1, 3, ..., 15) is taken exactly when flag F[(c-1)/2] is 1. The pairs are: 1 with F0 (zero), 3 with F1 (negative), 5 with F2 (carry), 7 with F3 (overflow), 9 with F4, 11 with F5, 13 with F6 and 15 with F7.
- R4: An even condition code c (2, 4, ..., 14) is taken exactly when flag F[c/2-1] is 0.
- R5: The conditional branch classes are class 1 (register), class 2 (immediate), class 5 (relative) and class 6 (relative indirect), each with destination field 1. For these the condition decides. Call classes 10, 11 and 12 are always taken, whatever the condition and destination fields hold.
- R6: For every other class, and for classes 1, 2, 5 and 6 with a destination other than 1, `br_taken` is 0.
- R7: For class 2 with a nonzero condition field, `imm_cond_br` is 1 when the destination is 1 and `imm_alu_op` is 1 otherwise. Both are 0 when the class is not 2 or the condition field is 0. The two are never 1 together.
- R8: On a clock edge with `alu_flag_we`=1 and `flag_restore`=0, F3..F0 take the value of `alu_flags`. F7..F4 stay unchanged. The new value is seen one cycle later.
- R9: On a clock edge with `flag_restore`=1, all eight flags take `restore_flags`. This holds even when `alu_flag_we` is also 1.
- R10: On a clock edge with neither strobe, the flags keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_class | input | 4 | Instruction class field |
| op_cond | input | 4 | Condition code field |
| op_dest | input | 4 | Destination field (1 = program counter) |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_flags | input | 4 | New F3..F0 from the ALU |
| flag_restore | input | 1 | Load all flags strobe |
| restore_flags | input | 8 | Flag value to restore |
| flags | output | 8 | Current flag register F7..F0 |
| br_taken | output | 1 | Branch taken |
| imm_cond_br | output | 1 | Immediate-class word is a conditional branch |
| imm_alu_op | output | 1 | Immediate-class word is an immediate ALU operation |

## Verification
`br_taken`, `imm_cond_br` and `imm_alu_op` are combinational from the instruction fields and the registered flags, so they are due in the same cycle that the fields are presented. Flag writes become visible one clock edge after the strobe. The bench drives the inputs on the falling edge and loads flags through the restore strobe. It then samples one time unit after the following rising edge, which leaves exactly one register between the strobe and the sample and none between the fields and the decision.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int CODE_W  = 4;
  localparam int FLAG_W  = 8;
  localparam int ALU_W   = 4;

  localparam logic [CODE_W-1:0] CLS_REG      = 4'd1;
  localparam logic [CODE_W-1:0] CLS_IMM      = 4'd2;
  localparam logic [CODE_W-1:0] CLS_REL      = 4'd5;
  localparam logic [CODE_W-1:0] CLS_REL_IND  = 4'd6;
  localparam logic [CODE_W-1:0] CLS_CALL     = 4'd10;
  localparam logic [CODE_W-1:0] CLS_CALL_REL = 4'd11;
  localparam logic [CODE_W-1:0] CLS_CALL_IND = 4'd12;
  localparam logic [CODE_W-1:0] DEST_PC      = 4'd1;
endpackage

// File: rtl/brc_flag_store.sv
module brc_flag_store #(
  parameter int FLAG_W = 8,
  parameter int ALU_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_we,
  input  logic [ALU_W-1:0]  upd_val,
  input  logic              rst_we,
  input  logic [FLAG_W-1:0] rst_val,
  output logic [FLAG_W-1:0] q
);
  localparam int HI_W = FLAG_W - ALU_W;

  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (rst_we)      nxt = rst_val;
    else if (upd_we) nxt = {q[FLAG_W-1 -: HI_W], upd_val};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/brc_cond_mux.sv
module brc_cond_mux #(
  parameter int FLAG_W = 8,
  parameter int CODE_W = 4
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [CODE_W-1:0] code,
  output logic              met
);
  localparam int NCODES = 1 << CODE_W;

  logic [NCODES-1:0] hit;

  assign hit[0] = 1'b1;

  for (genvar k = 1; k < NCODES; k++) begin : g_code
    localparam int IDX = (k - 1) / 2;
    if (IDX < FLAG_W) begin : g_flag
      if (k % 2 == 1) begin : g_set
        assign hit[k] = flags[IDX];
      end else begin : g_clr
        assign hit[k] = ~flags[IDX];
      end
    end else begin : g_none
      assign hit[k] = 1'b0;
    end
  end

  assign met = hit[code];
endmodule

// File: rtl/brc_class_decode.sv
module brc_class_decode
  import brc_pkg::*;
(
  input  logic [CODE_W-1:0] cls,
  input  logic [CODE_W-1:0] cond,
  input  logic [CODE_W-1:0] dest,
  output logic              cond_class,
  output logic              call_class,
  output logic              imm_br,
  output logic              imm_alu
);
  logic to_pc;
  logic is_imm;

  assign to_pc  = (dest == DEST_PC);
  assign is_imm = (cls == CLS_IMM);

  always_comb begin
    unique case (cls)
      CLS_REG, CLS_IMM, CLS_REL, CLS_REL_IND: cond_class = to_pc;
      default:                                cond_class = 1'b0;
    endcase
    unique case (cls)
      CLS_CALL, CLS_CALL_REL, CLS_CALL_IND: call_class = 1'b1;
      default:                              call_class = 1'b0;
    endcase
  end

  assign imm_br  = is_imm && (cond != '0) &&  to_pc;
  assign imm_alu = is_imm && (cond != '0) && !to_pc;
endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
  import brc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] op_class,
  input  logic [CODE_W-1:0] op_cond,
  input  logic [CODE_W-1:0] op_dest,
  input  logic              alu_flag_we,
  input  logic [ALU_W-1:0]  alu_flags,
  input  logic              flag_restore,
  input  logic [FLAG_W-1:0] restore_flags,
  output logic [FLAG_W-1:0] flags,
  output logic              br_taken,
  output logic              imm_cond_br,
  output logic              imm_alu_op
);
  logic cond_met;
  logic cond_class;
  logic call_class;

  brc_flag_store #(.FLAG_W(FLAG_W), .ALU_W(ALU_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_we  (alu_flag_we),
    .upd_val (alu_flags),
    .rst_we  (flag_restore),
    .rst_val (restore_flags),
    .q       (flags)
  );

  brc_cond_mux #(.FLAG_W(FLAG_W), .CODE_W(CODE_W)) u_mux (
    .flags (flags),
    .code  (op_cond),
    .met   (cond_met)
  );

  brc_class_decode u_dec (
    .cls        (op_class),
    .cond       (op_cond),
    .dest       (op_dest),
    .cond_class (cond_class),
    .call_class (call_class),
    .imm_br     (imm_cond_br),
    .imm_alu    (imm_alu_op)
  );

  assign br_taken = call_class | (cond_class & cond_met);
endmodule

// File: rtl/brc_checker.sv
module brc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] op_class,
  input logic [3:0] op_cond,
  input logic [3:0] op_dest,
  input logic       alu_flag_we,
  input logic [3:0] alu_flags,
  input logic       flag_restore,
  input logic [7:0] restore_flags,
  input logic [7:0] flags,
  input logic       br_taken,
  input logic       imm_cond_br,
  input logic       imm_alu_op
);
  logic brclass;
  assign brclass = (op_class == 4'd1 || op_class == 4'd2 ||
                    op_class == 4'd5 || op_class == 4'd6) && op_dest == 4'd1;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> flags == 8'h00);

  assert_uncond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (brclass && op_cond == 4'd0) |-> br_taken);

  assert_call_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 4'd10 || op_class == 4'd11 || op_class == 4'd12) |-> br_taken);

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!brclass && op_class != 4'd10 && op_class != 4'd11 && op_class != 4'd12)
      |-> !br_taken);

  assert_imm_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_cond_br && imm_alu_op));

  assert_alu_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_flag_we && !flag_restore) |=>
      (flags[3:0] == $past(alu_flags) && flags[7:4] == $past(flags[7:4])));

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_restore |=> flags == $past(restore_flags));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_flag_we && !flag_restore) |=> $stable(flags));
endmodule

bind brcond_eval brc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_class      (op_class),
  .op_cond       (op_cond),
  .op_dest       (op_dest),
  .alu_flag_we   (alu_flag_we),
  .alu_flags     (alu_flags),
  .flag_restore  (flag_restore),
  .restore_flags (restore_flags),
  .flags         (flags),
  .br_taken      (br_taken),
  .imm_cond_br   (imm_cond_br),
  .imm_alu_op    (imm_alu_op)
);

// File: tb/sim_brcond_eval.sv
module sim_brcond_eval;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;

  // {flags[26:19], class[18:15], cond[14:11], dest[10:7], req[6:3], taken[2], br[1], alu[0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h00, 4'd2,  4'd0,  4'd1, 4'd2, 3'b100},  // R2
    {8'h00, 4'd2,  4'd1,  4'd1, 4'd3, 3'b010},  // R3 F0 clear
    {8'h01, 4'd2,  4'd1,  4'd1, 4'd3, 3'b110},  // R3 F0 set
    {8'h01, 4'd2,  4'd2,  4'd1, 4'd4, 3'b010},  // R4
    {8'h00, 4'd1,  4'd2,  4'd1, 4'd4, 3'b100},  // R4 class 1
    {8'h02, 4'd5,  4'd3,  4'd1, 4'd3, 3'b100},  // R3 F1
    {8'h02, 4'd6,  4'd4,  4'd1, 4'd4, 3'b000},  // R4 F1
    {8'h04, 4'd5,  4'd5,  4'd1, 4'd3, 3'b100},  // R3 F2
    {8'h08, 4'd2,  4'd8,  4'd1, 4'd4, 3'b010},  // R4 F3
    {8'h80, 4'd2,  4'd15, 4'd1, 4'd3, 3'b110},  // R3 F7
    {8'h00, 4'd2,  4'd15, 4'd1, 4'd3, 3'b010},  // R3 F7 clear
    {8'h40, 4'd1,  4'd14, 4'd1, 4'd4, 3'b000},  // R4 F6
    {8'h10, 4'd2,  4'd9,  4'd1, 4'd3, 3'b110},  // R3 F4
    {8'h20, 4'd6,  4'd12, 4'd1, 4'd4, 3'b000},  // R4 F5
    {8'h00, 4'd2,  4'd3,  4'd4, 4'd7, 3'b001},  // R7 immediate ALU
    {8'h00, 4'd10, 4'd5,  4'd1, 4'd5, 3'b100},  // R5 call
    {8'h00, 4'd12, 4'd1,  4'd7, 4'd5, 3'b100},  // R5 call, dest ignored
    {8'hFF, 4'd3,  4'd0,  4'd1, 4'd6, 3'b000},  // R6
    {8'hFF, 4'd9,  4'd1,  4'd1, 4'd6, 3'b000},  // R6
    {8'h00, 4'd4,  4'd2,  4'd4, 4'd6, 3'b000}   // R6
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_class = '0, op_cond = '0, op_dest = '0;
  logic       alu_flag_we = 1'b0;
  logic [3:0] alu_flags = '0;
  logic       flag_restore = 1'b0;
  logic [7:0] restore_flags = '0;
  logic [7:0] flags;
  logic       br_taken, imm_cond_br, imm_alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brcond_eval u0 (
    .clk(clk), .rst_n(rst_n), .op_class(op_class), .op_cond(op_cond),
    .op_dest(op_dest), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
    .flag_restore(flag_restore), .restore_flags(restore_flags),
    .flags(flags), .br_taken(br_taken), .imm_cond_br(imm_cond_br),
    .imm_alu_op(imm_alu_op)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_flags(input logic [7:0] v);
    @(negedge clk);
    flag_restore = 1'b1;
    restore_flags = v;
    step();
    @(negedge clk);
    flag_restore = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    op_class = 4'd2; op_cond = 4'd10; op_dest = 4'd1;
    #1;
    check("R1 flags after reset", {24'h0, flags}, 32'h00);
    check("R1 code 10 taken after reset", {31'h0, br_taken}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      load_flags(VEC[i][26:19]);
      op_class = VEC[i][18:15];
      op_cond  = VEC[i][14:11];
      op_dest  = VEC[i][10:7];
      #1;
      check($sformatf("R%0d row %0d taken", VEC[i][6:3], i), {31'h0, br_taken}, {31'h0, VEC[i][2]});
      check($sformatf("R%0d row %0d imm_cond_br", VEC[i][6:3], i), {31'h0, imm_cond_br}, {31'h0, VEC[i][1]});
      check($sformatf("R%0d row %0d imm_alu_op", VEC[i][6:3], i), {31'h0, imm_alu_op}, {31'h0, VEC[i][0]});
    end

    // R7: class 2 with code 0 to PC is neither conditional branch nor ALU op
    @(negedge clk);
    op_class = 4'd2; op_cond = 4'd0; op_dest = 4'd1;
    #1;
    check("R7 code0 imm_cond_br", {31'h0, imm_cond_br}, 32'h0);
    check("R7 code0 imm_alu_op", {31'h0, imm_alu_op}, 32'h0);

    // R8: ALU update touches only F3..F0
    load_flags(8'hA0);
    alu_flag_we = 1'b1; alu_flags = 4'h5;
    step();
    @(negedge clk);
    alu_flag_we = 1'b0;
    check("R8 alu update", {24'h0, flags}, 32'hA5);

    // R9: restore beats ALU update
    alu_flag_we = 1'b1; alu_flags = 4'hF;
    flag_restore = 1'b1; restore_flags = 8'h3C;
    step();
    @(negedge clk);
    alu_flag_we = 1'b0; flag_restore = 1'b0;
    check("R9 restore priority", {24'h0, flags}, 32'h3C);

    // R10: no strobe holds flags, even with data pins moving
    alu_flags = 4'h0; restore_flags = 8'hFF;
    step(); step();
    check("R10 hold", {24'h0, flags}, 32'h3C);
    @(negedge clk);
    op_class = 4'd2; op_cond = 4'd6; op_dest = 4'd1;  // F2 is 1 -> not taken
    #1;
    check("R4 after hold F2 set code 6", {31'h0, br_taken}, 32'h0);

    // R1: reset mid-run clears all flags
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", {24'h0, flags}, 32'h00);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule